// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog counter of a small processor core. It counts one of three clock-enable ticks, chosen by a static option: a slow dedicated oscillator tick, the instruction clock tick (system clock divided by four), or a real-time oscillator tick. When the count reaches the selected time-out length, the block asks for a reset and sets a sticky time-out status flag. If the core is running, the request is a full chip reset. If the core is halted, the request is a warm reset that clears only the program counter and stack pointer.

Software keeps the counter from expiring by issuing clear commands. A static option chooses between two ways of clearing. In the first, one clear command is enough. In the second, two distinct clear commands must both be seen, in either order. Entering halt and the external reset also clear the counter. A disable option turns the whole block off. When it is off, the counter stays at zero, no command has any effect and no reset is ever requested. The analog oscillators, the core and the reset distribution live outside the block.

Top module: `watchdog_paired`

## Requirements
- R1: `optSrc` selects the counted tick: 0 = `rcTick`, 1 = `instrTick`, 2 = `rtcTick`, 3 = nothing counts. Each cycle in which the selected tick is high advances the count by one.
- R2: With `optDiv` = d, the time-out occurs on the 2^(BASE_LOG2+d)-th counted tick after the last clear (4096, 8192, 16384 or 32768 ticks at the default BASE_LOG2 = 12). The request appears in the cycle after the edge that sampled that tick.
- R3: A time-out while `halted` is low gives a one-cycle `coldRstReq` pulse. The count then restarts from zero.
- R4: A time-out while `halted` is high gives a one-cycle `warmRstReq` pulse instead. The two requests are never high together.
- R5: `timeoutFlag` is set by every time-out and stays set until `rstN` goes low.
- R6: While `rstN` is low, the count, both pair flags, `timeoutFlag` and both requests are zero.
- R7: A `cmdHalt` pulse clears the count, in either clear mode.
- R8: With `optPaired` = 0, a `cmdClr` pulse clears the count. `cmdClr1` and `cmdClr2` have no effect in this mode.
- R9: With `optPaired` = 1, the count clears in the cycle in which the second distinct command of `cmdClr1`/`cmdClr2` arrives. The two may come in either order or in the same cycle. Repeating only one of them never clears, and `cmdClr` has no effect in this mode.
- R10: Both pair flags drop after any clear or time-out. A command seen before a time-out therefore does not pair with one seen after it.
- R11: With `optSrc` = 1, the count does not advance while `halted` is high. With the other two sources it keeps counting while halted.
- R12: With `optEnable` low, the count is held at zero, every command is ignored, no request is issued and `timeoutFlag` is never set.
- R13: When a clear and a counted tick fall in the same cycle, the clear wins and the count becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | External reset, active low, asynchronous |
| optEnable | input | 1 | Static option: watchdog enabled |
| optSrc | input | 2 | Static option: tick source select |
| optDiv | input | SEL_W (2) | Static option: time-out length select |
| optPaired | input | 1 | Static option: paired-clear mode |
| rcTick | input | 1 | Dedicated slow oscillator tick |
| instrTick | input | 1 | Instruction clock tick |
| rtcTick | input | 1 | Real-time oscillator tick |
| halted | input | 1 | Core is in the halt state |
| cmdClr | input | 1 | Single clear command pulse |
| cmdClr1 | input | 1 | First paired clear command pulse |
| cmdClr2 | input | 1 | Second paired clear command pulse |
| cmdHalt | input | 1 | Halt command pulse |
| coldRstReq | output | 1 | Full chip reset request pulse |
| warmRstReq | output | 1 | Warm reset request pulse |
| timeoutFlag | output | 1 | Sticky time-out status |

## Verification
The three ticks run at different periods (every 3, 4 and 2 cycles), so each source gives a different overflow time, and a wrong source selection shows up as a request in the wrong cycle. Clear pulses are sent in runs that are shorter than the time-out, which separates a working clear from one that is ignored. The paired commands are sent in forward order, in reverse order, in the same cycle, as one command repeated, and split across a time-out; only a correct pair flag gives the expected request times in all five cases. Halted runs with the oscillator source and with the instruction source tell the warm request apart from the cold one, and counting apart from stopping. A long disabled run, followed by the block being enabled again, shows that nothing leaks through while the block is off.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Tick source encoding of the optSrc option
  typedef enum logic [1:0] {
    SRC_RC    = 2'd0,
    SRC_INSTR = 2'd1,
    SRC_RTC   = 2'd2,
    SRC_NONE  = 2'd3
  } wdSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero the count this cycle
    logic advance;  // one counted tick this cycle
  } wdStrobe_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int DIV_STEPS = 4,
  localparam int SEL_W = (DIV_STEPS > 1) ? $clog2(DIV_STEPS) : 1,
  localparam int CNT_W = BASE_LOG2 + DIV_STEPS - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [SEL_W-1:0] optDiv,
  output logic             wrapNow
);

  logic [CNT_W-1:0]     count;
  logic [DIV_STEPS-1:0] atEnd;
  logic                 selEnd;

  // One terminal compare per selectable length
  for (genvar g = 0; g < DIV_STEPS; g++) begin : gEnd
    localparam logic [CNT_W-1:0] LAST =
      CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    assign atEnd[g] = (count >= LAST);
  end

  always_comb begin
    selEnd = atEnd[DIV_STEPS-1];
    if (int'(optDiv) < DIV_STEPS) selEnd = atEnd[optDiv];
  end

  assign wrapNow = strobe.advance & ~strobe.clear & selEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.clear)   count <= '0;
    else if (strobe.advance) count <= wrapNow ? '0 : count + CNT_W'(1);
  end

  // Clear beats a simultaneous tick
  assert_clear_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0));

  // Restart from zero after a time-out
  assert_wrap_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> (count == '0));

  // A counted tick adds exactly one
  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear && !wrapNow) |=>
      (count == CNT_W'($past(count) + CNT_W'(1))));

  // No tick, no clear: count holds
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.clear) |=> $stable(count));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       optEnable,
  input  logic [1:0] optSrc,
  input  logic       optPaired,
  input  logic       rcTick,
  input  logic       instrTick,
  input  logic       rtcTick,
  input  logic       halted,
  input  logic       cmdClr,
  input  logic       cmdClr1,
  input  logic       cmdClr2,
  input  logic       cmdHalt,
  input  logic       wrapNow,
  output wdStrobe_t  strobe,
  output logic       coldRstReq,
  output logic       warmRstReq,
  output logic       timeoutFlag
);

  wdSrc_e srcSel;
  logic   selTick;
  logic   seen1;
  logic   seen2;
  logic   singleHit;
  logic   pairDone;

  assign srcSel = wdSrc_e'(optSrc);

  // The instruction clock stops while halted
  always_comb begin
    case (srcSel)
      SRC_RC:    selTick = rcTick;
      SRC_INSTR: selTick = instrTick & ~halted;
      SRC_RTC:   selTick = rtcTick;
      default:   selTick = 1'b0;
    endcase
  end

  assign singleHit = ~optPaired & cmdClr;
  assign pairDone  = optPaired &
                     ((cmdClr1 & (seen2 | cmdClr2)) | (cmdClr2 & seen1));

  assign strobe.clear   = ~optEnable | cmdHalt | singleHit | pairDone;
  assign strobe.advance = optEnable & selTick;

  // Pair flags record which paired command has been seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else if (strobe.clear || wrapNow) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else if (optPaired) begin
      seen1 <= seen1 | cmdClr1;
      seen2 <= seen2 | cmdClr2;
    end
  end

  // Request pulses and sticky status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coldRstReq  <= 1'b0;
      warmRstReq  <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      coldRstReq  <= wrapNow & ~halted;
      warmRstReq  <= wrapNow & halted;
      timeoutFlag <= timeoutFlag | wrapNow;
    end
  end

  assert_cold_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    coldRstReq |=> !coldRstReq);

  assert_warm_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    warmRstReq |=> !warmRstReq);

  assert_one_kind_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(coldRstReq && warmRstReq));

  assert_flag_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (coldRstReq || warmRstReq) |-> timeoutFlag);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |=> timeoutFlag);

  assert_off_silent_R12: assert property (@(posedge clk) disable iff (!rstN)
    !optEnable |=> (!coldRstReq && !warmRstReq));

  assert_pair_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear || wrapNow) |=> (!seen1 && !seen2));

  assert_instr_halt_R11: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SRC_INSTR && halted) |-> !strobe.advance);

endmodule

// File: rtl/watchdog_paired.sv
module watchdog_paired
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int DIV_STEPS = 4,
  localparam int SEL_W = (DIV_STEPS > 1) ? $clog2(DIV_STEPS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             optEnable,
  input  logic [1:0]       optSrc,
  input  logic [SEL_W-1:0] optDiv,
  input  logic             optPaired,
  input  logic             rcTick,
  input  logic             instrTick,
  input  logic             rtcTick,
  input  logic             halted,
  input  logic             cmdClr,
  input  logic             cmdClr1,
  input  logic             cmdClr2,
  input  logic             cmdHalt,
  output logic             coldRstReq,
  output logic             warmRstReq,
  output logic             timeoutFlag
);

  wdStrobe_t strobe;
  logic      wrapNow;

  wdog_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .optEnable  (optEnable),
    .optSrc     (optSrc),
    .optPaired  (optPaired),
    .rcTick     (rcTick),
    .instrTick  (instrTick),
    .rtcTick    (rtcTick),
    .halted     (halted),
    .cmdClr     (cmdClr),
    .cmdClr1    (cmdClr1),
    .cmdClr2    (cmdClr2),
    .cmdHalt    (cmdHalt),
    .wrapNow    (wrapNow),
    .strobe     (strobe),
    .coldRstReq (coldRstReq),
    .warmRstReq (warmRstReq),
    .timeoutFlag(timeoutFlag)
  );

  wdog_datapath #(
    .BASE_LOG2(BASE_LOG2),
    .DIV_STEPS(DIV_STEPS)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .optDiv (optDiv),
    .wrapNow(wrapNow)
  );

endmodule

// File: tb/sim_watchdog_paired.sv
`timescale 1ns/1ps
module sim_watchdog_paired;

  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       optEnable = 1'b1;
  logic [1:0] optSrc = 2'd0;
  logic [1:0] optDiv = 2'd0;
  logic       optPaired = 1'b0;
  logic       rcTick = 1'b0, instrTick = 1'b0, rtcTick = 1'b0;
  logic       halted = 1'b0;
  logic       cmdClr = 1'b0, cmdClr1 = 1'b0, cmdClr2 = 1'b0, cmdHalt = 1'b0;
  logic       coldRstReq, warmRstReq, timeoutFlag;

  int    checks = 0;
  int    fails = 0;
  int    cycleCnt = 0;
  int    genCnt = 0;
  string curReq = "R6";

  // Reference model state
  int mCnt = 0;
  bit m1 = 0, m2 = 0, mCold = 0, mWarm = 0, mTo = 0;

  watchdog_paired #(.BASE_LOG2(BASE), .DIV_STEPS(4)) u0 (
    .clk(clk), .rstN(rstN), .optEnable(optEnable), .optSrc(optSrc),
    .optDiv(optDiv), .optPaired(optPaired), .rcTick(rcTick),
    .instrTick(instrTick), .rtcTick(rtcTick), .halted(halted),
    .cmdClr(cmdClr), .cmdClr1(cmdClr1), .cmdClr2(cmdClr2), .cmdHalt(cmdHalt),
    .coldRstReq(coldRstReq), .warmRstReq(warmRstReq), .timeoutFlag(timeoutFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Tick generators with distinct periods
  always @(posedge clk) begin
    #5;
    genCnt++;
    rcTick    = (genCnt % 3 == 0);
    instrTick = (genCnt % 4 == 1);
    rtcTick   = (genCnt % 2 == 0);
  end

  // Behavioural reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; m1 = 0; m2 = 0; mCold = 0; mWarm = 0; mTo = 0;
    end else begin
      bit tk, clr, done, wrap;
      int limit;
      mCold = 0; mWarm = 0;
      if (!optEnable) begin
        mCnt = 0; m1 = 0; m2 = 0;
      end else begin
        case (optSrc)
          2'd0: tk = rcTick;
          2'd1: tk = instrTick && !halted;
          2'd2: tk = rtcTick;
          default: tk = 0;
        endcase
        done = optPaired && ((cmdClr1 && (m2 || cmdClr2)) || (cmdClr2 && m1));
        clr  = cmdHalt || (!optPaired && cmdClr) || done;
        limit = 1 << (BASE + optDiv);
        wrap = 0;
        if (clr) begin
          mCnt = 0; m1 = 0; m2 = 0;
        end else begin
          if (optPaired) begin
            m1 = m1 || cmdClr1;
            m2 = m2 || cmdClr2;
          end
          if (tk) begin
            if (mCnt + 1 >= limit) begin
              wrap = 1; mCnt = 0; m1 = 0; m2 = 0;
            end else mCnt++;
          end
        end
        if (wrap) begin
          if (halted) mWarm = 1; else mCold = 1;
          mTo = 1;
        end
      end
    end
  end

  // Compare away from the edge
  always @(posedge clk) begin
    #15;
    checks++;
    if ({coldRstReq, warmRstReq, timeoutFlag} !== {mCold, mWarm, mTo}) begin
      fails++;
      $display("FAIL %s cycle %0d: actual cold/warm/to=%b%b%b expected %b%b%b",
               curReq, cycleCnt, coldRstReq, warmRstReq, timeoutFlag,
               mCold, mWarm, mTo);
    end
  end

  // Watchdog on the bench itself
  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual cycles=%0d expected below 150000",
               cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // 1 = cmdClr, 2 = cmdClr1, 3 = cmdClr2, 4 = both paired, 5 = cmdHalt
  task automatic pulseCmd(int which);
    case (which)
      1: cmdClr = 1;
      2: cmdClr1 = 1;
      3: cmdClr2 = 1;
      4: begin cmdClr1 = 1; cmdClr2 = 1; end
      default: cmdHalt = 1;
    endcase
    cycles(1);
    cmdClr = 0; cmdClr1 = 0; cmdClr2 = 0; cmdHalt = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    cycles(2);
    rstN = 1;
  endtask

  initial begin
    curReq = "R6";
    cycles(3);
    rstN = 1;

    curReq = "R3"; optSrc = 2'd0; optDiv = 2'd0;
    cycles(70);
    curReq = "R5"; cycles(20);
    curReq = "R6"; doReset(); cycles(5);

    curReq = "R1";
    optSrc = 2'd2; cycles(80);
    optSrc = 2'd1; cycles(140);
    optSrc = 2'd3; cycles(100);

    curReq = "R2"; optSrc = 2'd2;
    for (int d = 1; d < 4; d++) begin
      optDiv = 2'(d);
      pulseCmd(5);
      cycles((2 << (BASE + d)) + 20);
    end
    optDiv = 2'd0;

    curReq = "R4"; optSrc = 2'd0; halted = 1;
    cycles(70);
    curReq = "R11"; optSrc = 2'd1;
    cycles(150);
    halted = 0; cycles(80);

    curReq = "R8"; optSrc = 2'd2; optPaired = 0;
    for (int i = 0; i < 20; i++) begin cycles(7); pulseCmd(1); end
    for (int i = 0; i < 20; i++) begin cycles(7); pulseCmd(2 + (i % 2)); end

    curReq = "R9"; optPaired = 1;
    for (int i = 0; i < 15; i++) begin cycles(5); pulseCmd(2); cycles(5); pulseCmd(3); end
    for (int i = 0; i < 15; i++) begin cycles(5); pulseCmd(3); cycles(5); pulseCmd(2); end
    for (int i = 0; i < 15; i++) begin cycles(9); pulseCmd(4); end
    for (int i = 0; i < 15; i++) begin cycles(5); pulseCmd(2); end
    for (int i = 0; i < 15; i++) begin cycles(5); pulseCmd(1); end

    curReq = "R10";
    for (int i = 0; i < 4; i++) begin
      pulseCmd(5); cycles(3);
      pulseCmd(2); cycles(35);
      pulseCmd(3); cycles(40);
    end

    curReq = "R7"; optPaired = 0;
    for (int i = 0; i < 20; i++) begin cycles(8); pulseCmd(5); end
    optPaired = 1;
    for (int i = 0; i < 20; i++) begin cycles(8); pulseCmd(5); end
    optPaired = 0;

    curReq = "R13"; optSrc = 2'd2;
    cmdClr = 1; cycles(100); cmdClr = 0;
    cycles(50);

    curReq = "R12"; doReset(); optEnable = 0;
    for (int i = 0; i < 10; i++) begin
      halted = (i % 2 == 1);
      cycles(15); pulseCmd(1 + (i % 5));
    end
    optPaired = 1; cycles(100);
    halted = 0; optPaired = 0; optEnable = 1;
    cycles(50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule